// File: doc/BRIEF.md
# Synchronous Burst Memory Access Controller

This block is the front end of a synchronous burst static memory with a small on-chip register array behind it. Every control input except the output enable is sampled on the rising clock edge. A cycle starts when either of two active-low address strobes is seen. One strobe comes from the processor side and the other from the cache-controller side. On that edge the external address is captured and a 2-bit beat counter is cleared. While a burst is open and no strobe arrives, a low advance input moves to the next beat and a high advance input holds the current address.

The low two bits of the array address follow one of two orders, chosen by a static input. In interleaved order they are the start bits XOR the beat. In linear order they are the start bits plus the beat, wrapping modulo 4. A second static input selects one of two output modes. In flow-through mode, read data leaves the array output register directly. In pipelined mode it passes through one more register. Read data is presented as a bus plus a valid flag. The output enable gates that flag without waiting for a clock edge.

Top module: `sbsram_ctrl`

## Requirements
- R1: After synchronous reset, with no strobe applied, `rvalid_o` stays 0.
- R2: With `ilv_i`=1, the low two array-address bits of beat n are start XOR n. For start 01 the order is 01, 00, 11, 10.
- R3: With `ilv_i`=0, the low two array-address bits of beat n are (start + n) mod 4. For start 01 the order is 01, 10, 11, 00. The upper address bits are not changed by the burst.
- R4: On an edge with no effective strobe and an open burst, `adv_n_i`=0 moves to the next beat. `adv_n_i`=1 repeats the access at the current address.
- R5: While `ce1_n_i`=1, the processor strobe is ignored and an open burst carries on. The controller strobe with `ce1_n_i`=1 closes the burst, and no further read data is marked valid.
- R6: A strobe opens a burst only if `ce1_n_i`=0, `ce2_i`=1 and `ce3_n_i`=0 on that edge. Otherwise the device is deselected. `ce2_i` and `ce3_n_i` are ignored on edges without a strobe.
- R7: A cycle opened by the processor strobe is a read on its first edge, whatever `we_n_i` is.
- R8: A controller-strobe edge with `we_n_i`=0 writes `wdata_i` at the external address. A no-strobe edge in an open burst with `we_n_i`=0 writes `wdata_i` at that edge's beat address. Written data is returned by later reads.
- R9: Read data for an access made on edge k is valid after edge k+1 with `pipe_i`=0, and after edge k+2 with `pipe_i`=1.
- R10: `oe_n_i`=1 forces `rvalid_o` to 0 at once, without a clock edge. Returning it to 0 restores the flag at once.
- R11: If both strobes are low while `ce1_n_i`=0, the processor strobe wins, so the cycle is a read. Any effective strobe during a burst restarts it at beat 0 from the new external address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | External word address |
| ce1_n_i | input | 1 | Chip enable 1, active low; masks the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high, sampled with a strobe |
| ce3_n_i | input | 1 | Chip enable 3, active low, sampled with a strobe |
| cpu_stb_n_i | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| we_n_i | input | 1 | Write request, active low |
| wdata_i | input | DW | Write data, sampled with the control inputs |
| ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| pipe_i | input | 1 | Output mode: 1 pipelined, 0 flow-through (static) |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions assume that `ilv_i` and `pipe_i` change only while reset is held. The bench therefore changes the two modes only at a reset. They also assume that nothing reads an array word before it has been written, because the array has no reset. Each mode therefore starts with bursts that fill every word. After that, the random phase may drive any mix of strobes, enables, advance, write and output enable. Each of these inputs has a defined meaning on every edge.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int BEAT_W = 2;

  // low address bits of a beat for the selected burst order
  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] beat,
                                                 input logic              ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/sbsram_cmd.sv
module sbsram_cmd #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_stb_n_i,
  input  logic          ctl_stb_n_i,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          adv_n_i,
  input  logic          we_n_i,
  input  logic [DW-1:0] wdata_i,
  output logic          load_o,
  output logic          step_o,
  output logic          act_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o
);
  logic cpu_go, ctl_go, start, sel;
  logic act_q, wr_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    cpu_go = !cpu_stb_n_i && !ce1_n_i;        // ce1 masks processor strobe
    ctl_go = !ctl_stb_n_i && !cpu_go;         // processor strobe has priority
    start  = cpu_go || ctl_go;
    sel    = !ce1_n_i && ce2_i && !ce3_n_i;   // ce2/ce3 only matter with a strobe
  end

  assign load_o  = start;
  assign step_o  = !start && act_q && !adv_n_i;
  assign act_o   = act_q;
  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (start) begin
      act_q <= sel;
      wr_q  <= ctl_go && !we_n_i;
    end else begin
      wr_q  <= !we_n_i;
    end
    wdata_q <= wdata_i;
  end

  // R7: processor-strobe cycle is a read on its first edge
  p_cpu_read_r7: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stb_n_i && !ce1_n_i) |=> !wr_q);
  // R5: controller strobe with ce1 inactive deselects
  p_ctl_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_stb_n_i && ce1_n_i) |=> !act_q);
  // R6: without any strobe the selection state is kept
  p_keep_sel_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_stb_n_i && ctl_stb_n_i) |=> (act_q == $past(act_q)));
endmodule

// File: rtl/sbsram_addr.sv
module sbsram_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic [AW-1:0] mem_addr_o
);
  import sbsram_pkg::*;

  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= ext_addr_i;
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low = beat_low(base_q[BEAT_W-1:0], beat_q, ilv_i);

  generate
    if (AW > BEAT_W) begin : g_wide
      assign mem_addr_o = {base_q[AW-1:BEAT_W], low};
    end else begin : g_narrow
      assign mem_addr_o = low[AW-1:0];
    end
  endgenerate

  // R11: a new burst starts at the external address
  p_load_addr_r11: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (mem_addr_o == $past(ext_addr_i)));
  // R4: suspended burst holds its address
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(mem_addr_o));
  // R4: an advance changes the address
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i) |=> (mem_addr_o != $past(mem_addr_o)));
endmodule

// File: rtl/sbsram_ram.sv
module sbsram_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/sbsram_out.sv
module sbsram_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_i,
  input  logic          oe_n_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] ram_d_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          v1_q, v2_q;
  logic [DW-1:0] d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_en_i;
      v2_q <= v1_q;
    end
    d2_q <= ram_d_i;
  end

  assign rdata_o  = pipe_i ? d2_q : ram_d_i;
  assign rvalid_o = (pipe_i ? v2_q : v1_q) && !oe_n_i;

  // R9: flow-through data one edge after the access
  p_flow_lat_r9: assert property (@(posedge clk) disable iff (rst)
    (!pipe_i && rd_en_i) |=> (rvalid_o || oe_n_i));
  // R9: pipelined data two edges after the access
  p_pipe_lat_r9: assert property (@(posedge clk) disable iff (rst)
    (pipe_i && rd_en_i) |=> ##1 (rvalid_o || oe_n_i));
  // R9: no flow-through data without an access
  p_flow_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!pipe_i && !rd_en_i) |=> !rvalid_o);
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          cpu_stb_n_i,
  input  logic          ctl_stb_n_i,
  input  logic          adv_n_i,
  input  logic          we_n_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ilv_i,
  input  logic          pipe_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          load, step, act, wr;
  logic [DW-1:0] wdata_q, ram_d;
  logic [AW-1:0] mem_addr;

  sbsram_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst),
    .cpu_stb_n_i(cpu_stb_n_i), .ctl_stb_n_i(ctl_stb_n_i),
    .ce1_n_i(ce1_n_i), .ce2_i(ce2_i), .ce3_n_i(ce3_n_i),
    .adv_n_i(adv_n_i), .we_n_i(we_n_i), .wdata_i(wdata_i),
    .load_o(load), .step_o(step), .act_o(act), .wr_o(wr), .wdata_o(wdata_q)
  );

  sbsram_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .ilv_i(ilv_i),
    .ext_addr_i(addr_i), .mem_addr_o(mem_addr)
  );

  sbsram_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we_i(act && wr), .re_i(act && !wr), .addr_i(mem_addr),
    .wdata_i(wdata_q), .rdata_o(ram_d)
  );

  sbsram_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .pipe_i(pipe_i), .oe_n_i(oe_n_i),
    .rd_en_i(act && !wr), .ram_d_i(ram_d), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // R1: nothing valid on the first edge after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !rvalid_o);
endmodule

// File: tb/sbsram_ctrl_tb.sv
module sbsram_ctrl_tb;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          b_rst = 1'b1;
  logic [AW-1:0] b_addr = '0;
  logic          b_ce1n = 1'b0, b_ce2 = 1'b1, b_ce3n = 1'b0;
  logic          b_cpun = 1'b1, b_ctln = 1'b1, b_advn = 1'b1, b_wen = 1'b1;
  logic [DW-1:0] b_wd = '0;
  logic          b_ilv = 1'b1, b_pipe = 1'b1, b_oen = 1'b0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  sbsram_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(b_rst), .addr_i(b_addr), .ce1_n_i(b_ce1n), .ce2_i(b_ce2),
    .ce3_n_i(b_ce3n), .cpu_stb_n_i(b_cpun), .ctl_stb_n_i(b_ctln), .adv_n_i(b_advn),
    .we_n_i(b_wen), .wdata_i(b_wd), .ilv_i(b_ilv), .pipe_i(b_pipe), .oe_n_i(b_oen),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // behavioural model
  logic [DW-1:0] mdl [1<<AW];
  logic          m_act = 1'b0, m_wr = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          q1v = 0, q2v = 0, q3v = 0;
  logic [DW-1:0] q1d = '0, q2d = '0, q3d = '0;
  int checks = 0, errors = 0;
  string cur = "R1";

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input logic [1:0] n,
                                               input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (base[1:0] ^ n) : (base[1:0] + n);
    return {base[AW-1:2], lo};
  endfunction

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic model();
    logic cpu_go, ctl_go;
    logic [AW-1:0] a;
    if (b_rst) begin
      m_act = 0; q1v = 0; q2v = 0; q3v = 0;
      return;
    end
    cpu_go = !b_cpun && !b_ce1n;
    ctl_go = !b_ctln && !cpu_go;
    if (cpu_go || ctl_go) begin
      m_act = !b_ce1n && b_ce2 && !b_ce3n;
      m_base = b_addr; m_cnt = 0;
      m_wr = ctl_go && !b_wen;
    end else begin
      if (m_act && !b_advn) m_cnt = m_cnt + 1;
      m_wr = !b_wen;
    end
    a = beat_addr(m_base, m_cnt, b_ilv);
    q3v = q2v; q3d = q2d; q2v = q1v; q2d = q1d;
    q1v = m_act && !m_wr; q1d = mdl[a];
    if (m_act && m_wr) mdl[a] = b_wd;
  endtask

  task automatic compare();
    logic ev;
    logic [DW-1:0] ed;
    ev = b_pipe ? q3v : q2v;
    ed = b_pipe ? q3d : q2d;
    check({cur, " valid"}, DW'(rvalid_o), DW'(ev && !b_oen));
    if (ev && !b_oen && rvalid_o) check({cur, " data"}, rdata_o, ed);
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(input logic cpun, input logic ctln, input logic ce1n, input logic ce2,
                     input logic ce3n, input logic advn, input logic wen,
                     input logic [AW-1:0] a, input logic [DW-1:0] wd);
    b_cpun = cpun; b_ctln = ctln; b_ce1n = ce1n; b_ce2 = ce2; b_ce3n = ce3n;
    b_advn = advn; b_wen = wen; b_addr = a; b_wd = wd;
    tick();
  endtask

  task automatic idle(input logic advn);
    cyc(1, 1, 0, 1, 0, advn, 1, '0, '0);
  endtask

  task automatic deselect();
    cyc(1, 0, 1, 1, 0, 1, 1, '0, '0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int mode = 0; mode < 4; mode++) begin
      @(negedge clk);
      b_rst = 1; b_ilv = mode[0]; b_pipe = mode[1]; b_oen = 0;
      cur = "R1";
      idle(1); idle(1);
      b_rst = 0;
      idle(1); idle(1);
      check("R1 reset quiet", DW'(rvalid_o), '0);

      // R8: fill the array with controller-strobe write bursts
      cur = "R8";
      for (int b = 0; b < (1 << AW) / 4; b++) begin
        cyc(1, 0, 0, 1, 0, 1, 0, AW'(4 * b), $urandom);
        for (int k = 0; k < 3; k++) cyc(1, 1, 0, 1, 0, 0, 0, '0, $urandom);
      end
      deselect();

      // R9 latency from a processor start, with we_n low (R7)
      cur = "R9";
      idle(1); idle(1);
      cyc(0, 1, 0, 1, 0, 1, 0, 6'd9, '1);
      check("R9 start edge", DW'(rvalid_o), '0);
      idle(1);
      check("R9 first data edge", DW'(rvalid_o), DW'(!b_pipe));
      cur = "R7";
      idle(1);
      check("R7 read despite we_n", DW'(rvalid_o), DW'(1));

      // R2/R3 order and R4 advance/suspend
      cur = b_ilv ? "R2" : "R3";
      cyc(0, 1, 0, 1, 0, 1, 1, 6'd13, '0);
      for (int k = 0; k < 5; k++) idle(0);
      cur = "R4";
      idle(1); idle(1); idle(0); idle(1);

      // R10 output enable is asynchronous
      cur = "R10";
      b_oen = 1; #1;
      check("R10 oe high", DW'(rvalid_o), '0);
      b_oen = 0; #1;
      check("R10 oe low", DW'(rvalid_o), DW'(1));

      // R6: ce2/ce3 ignored mid-burst
      cur = "R6";
      cyc(1, 1, 0, 0, 1, 0, 1, '0, '0);
      cyc(1, 1, 1, 0, 1, 1, 1, '0, '0);
      // R5: processor strobe masked by ce1, burst continues
      cur = "R5";
      cyc(0, 1, 1, 1, 0, 0, 1, 6'd50, '0);
      idle(1);
      check("R5 burst survives masked strobe", DW'(rvalid_o), DW'(1));
      deselect(); idle(1); idle(1); idle(1);
      check("R5 controller strobe deselects", DW'(rvalid_o), '0);
      // R6: strobe with ce2 low or ce3 high deselects
      cur = "R6";
      cyc(0, 1, 0, 0, 0, 1, 1, 6'd20, '0);
      idle(1); idle(1); idle(1);
      check("R6 ce2 low deselect", DW'(rvalid_o), '0);
      cyc(1, 0, 0, 1, 1, 1, 1, 6'd20, '0);
      idle(1); idle(1); idle(1);
      check("R6 ce3 high deselect", DW'(rvalid_o), '0);

      // R11 restart mid-burst and strobe priority
      cur = "R11";
      cyc(0, 1, 0, 1, 0, 0, 1, 6'd22, '0);
      idle(0);
      cyc(1, 0, 0, 1, 0, 0, 1, 6'd35, '0);
      idle(0); idle(0);
      cyc(0, 0, 0, 1, 0, 1, 0, 6'd41, '0);
      idle(1); idle(1);
      check("R11 cpu strobe wins, read", DW'(rvalid_o), DW'(1));

      // R8: write on continue cycle, read back
      cur = "R8";
      cyc(0, 1, 0, 1, 0, 1, 1, 6'd44, '0);
      cyc(1, 1, 0, 1, 0, 1, 0, '0, 32'hC0FFEE00 + mode);
      idle(1); idle(1); idle(1);
      check("R8 write readback", rdata_o, 32'hC0FFEE00 + mode);

      // random phase
      cur = "R11 random R4";
      for (int i = 0; i < 250; i++) begin
        b_oen = ($urandom_range(0, 9) == 0);
        cyc($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
            $urandom_range(0, 5) == 0, $urandom_range(0, 5) != 0,
            $urandom_range(0, 5) == 0, 1'($urandom_range(0, 1)),
            $urandom_range(0, 2) != 0, AW'($urandom), $urandom);
      end
      b_oen = 0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule